// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to 64 interrupt inputs and produces a single request line for a processor. Each input has its own mask bit and its own setup word. The setup word chooses how the input is sensed and what urgency it carries. A level-sensed input is pending while it is held high. An edge-sensed input keeps a sticky flag from the first rising edge until software clears it.

Software reads a vector word to find which source to service. That read also records the priority now in service, so sources of equal or lower urgency cannot interrupt the handler. A write of any value to the end-of-interrupt word closes the service window. A soft-reset word clears all programmable state. The request line is also gated by a global generation-enable bit.

All access goes through a 32-bit bus addressed by word. Read data is combinational from the addressed register. A write takes effect at the clock edge on which the select and write strobes are sampled.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_out is low, the vector word (word 2) reads 0xFF, and the generation word (1), the mask words (4 to 7) and every setup word read zero.
- R2: Writing ones to word 4 (sources 0-31) or word 5 (sources 32-63) unmasks those sources. Writing ones to word 6 or word 7 masks them. Zero bits leave the mask alone. Words 4 and 6 both read back the low mask half, and words 5 and 7 both read back the high half.
- R3: Source n has a setup word at word 64 + 2n. Bit 8 selects edge sensing, and bits 3:0 hold the priority. Both fields read back as written.
- R4: A source in level mode is pending one clock after its input goes high. It stops being pending one clock after the input goes low.
- R5: A source in edge mode latches a rising edge of its input. It stays pending after the input returns low.
- R6: Writing a source's setup word with bit 8 clear discards its latched edge. Writing the edge-mode value back afterwards does not bring the old event back.
- R7: The vector word returns the index of the unmasked pending source with the highest priority, and the lowest index on a tie. It returns 0xFF when no unmasked source is pending.
- R8: irq_out can be high only while bit 0 of word 1 is set. The vector word does not depend on that bit.
- R9: A vector read that returns a source which may interrupt enters service at that source's priority. While in service, irq_out stays low unless the best pending priority is strictly higher than the service priority.
- R10: A write of any data to word 3 ends service, so sources at any priority may interrupt again.
- R11: Writing a 1 in bit 0 of word 0 clears the masks, the setup words, the edge latches, the service state and the generation bit.
- R12: A masked source neither raises irq_out nor appears in the vector word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| src_in | input | 64 | Interrupt source inputs |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench covers ties in priority. A design that compares the wrong way would report the higher index of two equal sources. It also covers a source at priority zero, which a design treating zero as "off" would never report. The edge flag is cleared and then edge mode is restored without a new edge. A design that re-detects the held level, or never clears the flag, would report the stale source. Service masking is tested with a later source of equal priority, which must stay silent, and one of higher priority, which must break through. A design that uses a greater-or-equal test, or forgets the in-service state, gets one of these two cases wrong.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   localparam int unsigned WORD_SOFT_RST = 0;
   localparam int unsigned WORD_GEN_EN   = 1;
   localparam int unsigned WORD_VECTOR   = 2;
   localparam int unsigned WORD_EOI      = 3;
   localparam int unsigned WORD_UNMASK   = 4;   // 4 low half, 5 high half
   localparam int unsigned WORD_MASK     = 6;   // 6 low half, 7 high half
   localparam int unsigned WORD_SETUP    = 64;  // setup of source n at 64 + 2n
   localparam int unsigned SETUP_STRIDE  = 2;
   localparam int unsigned EDGE_BIT      = 8;
   localparam logic [7:0]  NO_SOURCE     = 8'hFF;
endpackage

// File: rtl/prio_irq_slice.sv
module prio_irq_slice #(
   parameter int PRIO_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              setup_we,
   input  logic              wd_edge,
   input  logic [PRIO_W-1:0] wd_prio,
   input  logic              mask_set,
   input  logic              mask_clr,
   input  logic              src_in,
   output logic              req,
   output logic              edge_mode,
   output logic              enabled,
   output logic [PRIO_W-1:0] prio
);
   logic src_q;
   logic latch_q;
   logic mode_next;
   logic rise;

   assign rise      = src_in & ~src_q;
   assign mode_next = setup_we ? wd_edge : edge_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= 1'b0;
      else        src_q <= src_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_mode <= 1'b0;
         prio      <= '0;
         latch_q   <= 1'b0;
         enabled   <= 1'b0;
      end else if (soft_rst) begin
         edge_mode <= 1'b0;
         prio      <= '0;
         latch_q   <= 1'b0;
         enabled   <= 1'b0;
      end else begin
         if (setup_we) begin
            edge_mode <= wd_edge;
            prio      <= wd_prio;
         end
         latch_q <= mode_next & (latch_q | rise);
         enabled <= (enabled | mask_set) & ~mask_clr;
      end
   end

   assign req = enabled & (edge_mode ? latch_q : src_q);

   assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_mode && !setup_we && !soft_rst && src_in && !src_q) |=> latch_q);
   assert_latch_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (setup_we && !wd_edge) |=> !latch_q);
   assert_mask_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mask_clr |=> !enabled);
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter #(
   parameter int N      = 64,
   parameter int PRIO_W = 4,
   localparam int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]        req,
   input  logic [N*PRIO_W-1:0] prio_flat,
   output logic                found,
   output logic [IDX_W-1:0]    best_idx,
   output logic [PRIO_W-1:0]   best_prio
);
   // Scan from the top index down; ">=" lets a lower index take a tie.
   always_comb begin
      found     = 1'b0;
      best_idx  = '0;
      best_prio = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] >= best_prio)) begin
            found     = 1'b1;
            best_idx  = IDX_W'(i);
            best_prio = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
   import prio_irq_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int ADDR_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   input  logic [NUM_SRC-1:0] src_in,
   output logic               irq_out
);
   localparam int IDX_W  = $clog2(NUM_SRC);
   localparam int HALVES = NUM_SRC / 32;

   if (NUM_SRC != 32 && NUM_SRC != 64) begin : g_bad_num
      $error("NUM_SRC must be 32 or 64");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must lie in 1..8");
   end
   if (WORD_SETUP + SETUP_STRIDE * NUM_SRC > 2 ** ADDR_W) begin : g_bad_addr
      $error("ADDR_W too narrow for the setup words");
   end

   logic wr, rd, soft_rst, gen_en, in_svc;
   logic [PRIO_W-1:0] svc_prio;
   assign wr       = bus_sel & bus_wr;
   assign rd       = bus_sel & ~bus_wr;
   assign soft_rst = wr && (bus_addr == ADDR_W'(WORD_SOFT_RST)) && bus_wdata[0];

   // setup word decode
   logic [ADDR_W-1:0] setup_off;
   logic              setup_hit;
   logic [IDX_W-1:0]  setup_idx;
   assign setup_off = bus_addr - ADDR_W'(WORD_SETUP);
   assign setup_hit = (bus_addr >= ADDR_W'(WORD_SETUP)) && !setup_off[0]
                      && (int'(setup_off[ADDR_W-1:1]) < NUM_SRC);
   assign setup_idx = setup_off[IDX_W:1];

   logic [NUM_SRC-1:0]        req_vec, en_vec, edge_vec;
   logic [NUM_SRC*PRIO_W-1:0] prio_flat;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      localparam int H = i / 32;
      localparam int B = i % 32;
      logic [PRIO_W-1:0] p;
      prio_irq_slice #(.PRIO_W(PRIO_W)) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .setup_we (wr && setup_hit && (setup_idx == IDX_W'(i))),
         .wd_edge  (bus_wdata[EDGE_BIT]),
         .wd_prio  (bus_wdata[PRIO_W-1:0]),
         .mask_set (wr && (bus_addr == ADDR_W'(WORD_UNMASK + H)) && bus_wdata[B]),
         .mask_clr (wr && (bus_addr == ADDR_W'(WORD_MASK + H)) && bus_wdata[B]),
         .src_in   (src_in[i]),
         .req      (req_vec[i]),
         .edge_mode(edge_vec[i]),
         .enabled  (en_vec[i]),
         .prio     (p)
      );
      assign prio_flat[i*PRIO_W +: PRIO_W] = p;
   end

   logic              best_valid;
   logic [IDX_W-1:0]  best_idx;
   logic [PRIO_W-1:0] best_prio;
   prio_irq_arbiter #(.N(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .req      (req_vec),
      .prio_flat(prio_flat),
      .found    (best_valid),
      .best_idx (best_idx),
      .best_prio(best_prio)
   );

   logic [7:0] vec_code;
   logic       eligible;
   assign vec_code = best_valid ? 8'(best_idx) : NO_SOURCE;
   assign eligible = best_valid && (!in_svc || best_prio > svc_prio);
   assign irq_out  = gen_en && eligible;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_en   <= 1'b0;
         in_svc   <= 1'b0;
         svc_prio <= '0;
      end else if (soft_rst) begin
         gen_en   <= 1'b0;
         in_svc   <= 1'b0;
         svc_prio <= '0;
      end else begin
         if (wr && bus_addr == ADDR_W'(WORD_GEN_EN)) gen_en <= bus_wdata[0];
         if (wr && bus_addr == ADDR_W'(WORD_EOI)) begin
            in_svc <= 1'b0;
         end else if (rd && bus_addr == ADDR_W'(WORD_VECTOR) && eligible) begin
            in_svc   <= 1'b1;
            svc_prio <= best_prio;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(WORD_GEN_EN)) bus_rdata[0] = gen_en;
      if (bus_addr == ADDR_W'(WORD_VECTOR)) bus_rdata[7:0] = vec_code;
      for (int h = 0; h < HALVES; h++) begin
         if (bus_addr == ADDR_W'(WORD_UNMASK + h) || bus_addr == ADDR_W'(WORD_MASK + h))
            bus_rdata = en_vec[h*32 +: 32];
      end
      if (setup_hit) begin
         bus_rdata[EDGE_BIT]     = edge_vec[setup_idx];
         bus_rdata[PRIO_W-1:0]   = prio_flat[setup_idx*PRIO_W +: PRIO_W];
      end
   end

   assert_winner_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      best_valid |-> req_vec[best_idx]);
   assert_vector_read_enters_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == ADDR_W'(WORD_VECTOR) && irq_out) |=> in_svc);
   assert_eoi_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && bus_addr == ADDR_W'(WORD_EOI)) |=> !in_svc);
   assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!gen_en && !irq_out && en_vec == '0));
endmodule

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/100ps
module prio_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] src_in = '0;
   logic        irq_out;
   int checks = 0;
   int errors = 0;
   logic [31:0] rv;

   always #2.5 clk = ~clk;

   prio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_in(src_in), .irq_out(irq_out)
   );

   typedef struct packed {
      logic [63:0] src;
      logic [7:0]  vec;
      logic        irq;
   } vec_t;

   // sources: 0 prio0, 5 prio3, 9 prio3, 40 prio7, 63 prio1 (all level)
   localparam vec_t TABLE [8] = '{
      '{64'h0,                               8'hFF, 1'b0},
      '{64'h1 << 5,                          8'd5,  1'b1},
      '{(64'h1 << 5) | (64'h1 << 9),         8'd5,  1'b1},
      '{(64'h1 << 9) | (64'h1 << 63),        8'd9,  1'b1},
      '{(64'h1 << 5) | (64'h1 << 40),        8'd40, 1'b1},
      '{64'h1 << 63,                         8'd63, 1'b1},
      '{64'h1,                               8'd0,  1'b1},
      '{64'h1 | (64'h1 << 63),               8'd63, 1'b1}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic drive_src(input logic [63:0] v);
      @(negedge clk);
      src_in = v;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 irq", 32'(irq_out), 0);
      bus_read(8'd2, rv);  check("R1 vector", rv, 32'hFF);
      bus_read(8'd1, rv);  check("R1 gen", rv, 0);
      bus_read(8'd4, rv);  check("R1 mask lo", rv, 0);
      bus_read(8'd7, rv);  check("R1 mask hi", rv, 0);
      bus_read(8'd190, rv); check("R1 setup63", rv, 0);

      // R2 set/clear masks, zero bits inert
      bus_write(8'd4, 32'h22);   bus_read(8'd4, rv); check("R2 set lo", rv, 32'h22);
      bus_write(8'd4, 32'h01);   bus_read(8'd4, rv); check("R2 zero bits keep", rv, 32'h23);
      bus_write(8'd6, 32'h02);   bus_read(8'd6, rv); check("R2 clear lo", rv, 32'h21);
      bus_write(8'd5, 32'h100);  bus_read(8'd7, rv); check("R2 set hi", rv, 32'h100);
      bus_write(8'd7, 32'h0);    bus_read(8'd5, rv); check("R2 clear zero inert", rv, 32'h100);

      // R3 setup words
      bus_write(8'd64, 32'h0);
      bus_write(8'd74, 32'h3);
      bus_write(8'd82, 32'h3);
      bus_write(8'd144, 32'h7);
      bus_write(8'd190, 32'h101);
      bus_read(8'd190, rv); check("R3 setup63 edge+prio", rv, 32'h101);
      bus_write(8'd190, 32'h1);
      bus_read(8'd190, rv); check("R3 setup63 level", rv, 32'h1);
      bus_read(8'd144, rv); check("R3 setup40", rv, 32'h7);

      bus_write(8'd4, 32'hFFFF_FFFF);
      bus_write(8'd5, 32'hFFFF_FFFF);
      bus_write(8'd1, 32'h1);

      // R7 priority table
      for (int k = 0; k < 8; k++) begin
         drive_src(TABLE[k].src);
         check($sformatf("R7 irq row %0d", k), 32'(irq_out), 32'(TABLE[k].irq));
         bus_read(8'd2, rv);
         check($sformatf("R7 vector row %0d", k), rv, 32'(TABLE[k].vec));
         bus_write(8'd3, 32'h0);
      end

      // R4 level drop
      drive_src(64'h1 << 5);
      check("R4 level high", 32'(irq_out), 1);
      drive_src(64'h0);
      check("R4 level low", 32'(irq_out), 0);

      // R12 masking
      bus_write(8'd7, 32'h100);
      drive_src((64'h1 << 40) | (64'h1 << 63));
      bus_read(8'd2, rv); check("R12 masked skipped", rv, 32'd63);
      bus_write(8'd3, 32'h0);
      drive_src(64'h1 << 40);
      check("R12 masked no irq", 32'(irq_out), 0);
      bus_read(8'd2, rv); check("R12 masked vector", rv, 32'hFF);
      bus_write(8'd5, 32'h100);

      // R8 generation enable
      bus_write(8'd1, 32'h0);
      drive_src(64'h1 << 5);
      check("R8 gen off irq", 32'(irq_out), 0);
      bus_read(8'd2, rv); check("R8 vector without gen", rv, 32'd5);
      bus_write(8'd3, 32'h0);
      bus_write(8'd1, 32'h1);
      check("R8 gen on irq", 32'(irq_out), 1);

      // R9 / R10 service window
      drive_src(64'h1 << 9);
      bus_read(8'd2, rv); check("R9 vector", rv, 32'd9);
      check("R9 in service low", 32'(irq_out), 0);
      drive_src((64'h1 << 9) | (64'h1 << 5));
      check("R9 equal prio blocked", 32'(irq_out), 0);
      drive_src((64'h1 << 9) | (64'h1 << 5) | (64'h1 << 40));
      check("R9 higher prio breaks in", 32'(irq_out), 1);
      bus_read(8'd2, rv); check("R9 nested vector", rv, 32'd40);
      check("R9 prio7 in service", 32'(irq_out), 0);
      bus_write(8'd3, 32'hDEAD_BEEF);
      check("R10 eoi reopens", 32'(irq_out), 1);
      drive_src(64'h0);

      // R5 / R6 edge mode on source 20
      bus_write(8'd104, 32'h105);
      drive_src(64'h1 << 20);
      drive_src(64'h0);
      check("R5 sticky irq", 32'(irq_out), 1);
      bus_read(8'd2, rv); check("R5 sticky vector", rv, 32'd20);
      bus_write(8'd3, 32'h0);
      bus_write(8'd104, 32'h005);
      check("R6 cleared irq", 32'(irq_out), 0);
      bus_write(8'd104, 32'h105);
      check("R6 no relatch irq", 32'(irq_out), 0);
      bus_read(8'd2, rv); check("R6 no relatch vector", rv, 32'hFF);
      drive_src(64'h1 << 20);
      drive_src(64'h0);
      bus_read(8'd2, rv); check("R5 new edge", rv, 32'd20);
      bus_write(8'd3, 32'h0);

      // R11 soft reset
      bus_write(8'd0, 32'h1);
      bus_read(8'd1, rv);   check("R11 gen cleared", rv, 0);
      bus_read(8'd4, rv);   check("R11 mask cleared", rv, 0);
      bus_read(8'd104, rv); check("R11 setup cleared", rv, 0);
      drive_src(64'h1 << 5);
      check("R11 irq off", 32'(irq_out), 0);
      bus_read(8'd2, rv);   check("R11 vector", rv, 32'hFF);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule